// File: doc/BRIEF.md
# Black Level Clamp Pulse Generator

This block creates one clamp pulse per video line in the pixel clock domain. Downstream, that pulse drives DC restore of AC-coupled inputs and also starts black-level calibration. An internal pixel counter restarts on the chosen HSYNC edge. The pulse opens when the count reaches a programmable start position and stays open for a programmable number of pixels. A control field can hand the pulse over to an external clamp pin instead.

The block also keeps per-channel offset and gain settings in two stages. A register write only changes the staged copy. The active copies, which are the values the converters would see, are loaded from the staged copies on the clamp leading edge and at no other time. On that same edge the block issues a one-clock calibration start strobe.

Top module: `clamp_pulse_gen`

## Requirements
- R1: After reset the outputs are as follows: `clamp_out` and `cal_start` are low and every active offset and gain is zero. The pulse width setting is 16 and the start position is 0. The trailing HSYNC edge is selected and the internal source is in use.
- R2: In internal mode, let the selected HSYNC edge show up on `hsync_in` just before rising clock edge 1. With start S and width W ≥ 2, `clamp_out` goes high after edge S+2 and stays high for exactly W clocks.
- R3: The start position is 13 bits wide. Address 0x0 bits 4:0 supply start bits 12:8, and address 0x1 supplies bits 7:0.
- R4: The width is written at address 0x2. A width of 0 or 1 produces no internal pulse. A width of 2 produces a two-clock pulse.
- R5: Control register 0x3 bit 2 selects the HSYNC edge. 0 selects the falling (trailing) edge and 1 selects the rising (leading) edge. The edge that is not selected has no effect.
- R6: When control bits 1:0 equal 01, `clamp_out` copies `clamp_ext_in` one clock late, and both the width and HSYNC are ignored. The codes 00, 10 and 11 select the internal pulse.
- R7: A selected HSYNC edge that arrives during a pulse drives `clamp_out` low on the next clock and restarts the count from zero.
- R8: `cal_start` is high for one clock, in the same cycle that `clamp_out` first goes high, for every rising of `clamp_out` from either source.
- R9: Staged offsets (addresses 0x4+i) and gains (addresses 0x8+i) for channel i do not change the active outputs until a clamp leading edge. At that edge they are copied, with either source. Channel i occupies bits [8i+7:8i] of `offset_act` and `gain_act`.
- R10: If a staged register is written several times, only the last value is transferred. A write in the cycle whose clock edge raises the clamp is part of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync, active high |
| clamp_ext_in | input | 1 | External clamp pin |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| clamp_out | output | 1 | Clamp pulse |
| cal_start | output | 1 | Calibration start strobe |
| offset_act | output | 24 | Active offsets, 3 channels |
| gain_act | output | 24 | Active gains, 3 channels |

## Verification
A register write and a clamp leading edge can land on the same clock edge. In that case the staged value being written and the transfer to the active copy meet in a single cycle. The bench sets up this collision by issuing a write to an offset register on the exact clock edge where the clamp rises, and it expects the active output to show the newly written value in that same cycle. A second collision is also exercised: a new HSYNC edge that arrives while a pulse is running, so that the pulse cut-off and the counter restart happen together. There the bench checks that a fresh pulse and a fresh calibration strobe follow at the normal offset.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
  localparam int CFG_AW = 4;

  localparam logic [CFG_AW-1:0] A_START_HI = 4'h0;
  localparam logic [CFG_AW-1:0] A_START_LO = 4'h1;
  localparam logic [CFG_AW-1:0] A_WIDTH    = 4'h2;
  localparam logic [CFG_AW-1:0] A_CTRL     = 4'h3;
  localparam int A_OFS_BASE  = 4;
  localparam int A_GAIN_BASE = 8;

  localparam int CTRL_EDGE_BIT = 2;

  typedef enum logic [1:0] {
    SRC_INTERNAL = 2'b00,
    SRC_EXTERNAL = 2'b01,
    SRC_SPARE_A  = 2'b10,
    SRC_SPARE_B  = 2'b11
  } clamp_src_e;
endpackage

// File: rtl/clamp_hs_edge.sv
module clamp_hs_edge (
  input  logic clk,
  input  logic rst,
  input  logic hsync_in,
  input  logic lead_sel,
  output logic edge_hit
);
  logic hs_d;

  always_ff @(posedge clk) begin
    if (rst) hs_d <= 1'b0;
    else     hs_d <= hsync_in;
  end

  // lead_sel=1: rising edge, lead_sel=0: falling edge
  always_comb begin
    if (lead_sel) edge_hit = hsync_in & ~hs_d;
    else          edge_hit = ~hsync_in & hs_d;
  end
endmodule

// File: rtl/clamp_window_counter.sv
module clamp_window_counter #(
  parameter int START_W = 13,
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic [START_W-1:0] start_pos,
  input  logic [WIDTH_W-1:0] width_px,
  output logic               in_window
);
  localparam int CNT_W = START_W + 1;
  localparam int SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [WIDTH_W-1:0] MIN_WIDTH = WIDTH_W'(2);

  logic [CNT_W-1:0] cnt;
  logic             running;
  logic [SUM_W-1:0] win_lo;
  logic [SUM_W-1:0] win_hi;
  logic [SUM_W-1:0] cnt_ext;
  logic             wide_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (restart) begin
      cnt     <= '0;
      running <= 1'b1;
    end else if (running && (cnt != CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    win_lo    = SUM_W'(start_pos);
    win_hi    = win_lo + SUM_W'(width_px);
    cnt_ext   = SUM_W'(cnt);
    wide_ok   = (width_px >= MIN_WIDTH);
    in_window = running && wide_ok && !restart &&
                (cnt_ext >= win_lo) && (cnt_ext < win_hi);
  end
endmodule

// File: rtl/clamp_stage_bank.sv
module clamp_stage_bank #(
  parameter int NCH   = 3,
  parameter int DW    = 8,
  parameter int REG_W = 8,
  parameter int AW    = 4,
  parameter int BASE  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              xfer,
  output logic [NCH*DW-1:0] act_flat
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DW-1:0] stage_q;
    logic [DW-1:0] stage_nx;
    logic [DW-1:0] act_q;
    logic          hit;

    always_comb begin
      hit      = wr_en && (wr_addr == AW'(BASE + ch));
      stage_nx = hit ? wr_data[DW-1:0] : stage_q;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q <= '0;
        act_q   <= '0;
      end else begin
        stage_q <= stage_nx;
        if (xfer) act_q <= stage_nx;
      end
    end

    assign act_flat[ch*DW +: DW] = act_q;
  end
endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
  import clamp_pkg::*;
#(
  parameter int START_W   = 13,
  parameter int REG_W     = 8,
  parameter int NCH       = 3,
  parameter int OFS_W     = 8,
  parameter int GAIN_W    = 8,
  parameter int WIDTH_RST = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hsync_in,
  input  logic                  clamp_ext_in,
  input  logic                  cfg_wr,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [REG_W-1:0]      cfg_wdata,
  output logic                  clamp_out,
  output logic                  cal_start,
  output logic [NCH*OFS_W-1:0]  offset_act,
  output logic [NCH*GAIN_W-1:0] gain_act
);
  localparam int HI_W = START_W - REG_W;

  logic [HI_W-1:0]    start_hi_q;
  logic [REG_W-1:0]   start_lo_q;
  logic [REG_W-1:0]   width_q;
  clamp_src_e         src_q;
  logic               lead_q;
  logic               ext_sel;
  logic               hs_edge;
  logic               int_pulse;
  logic               next_clamp;
  logic               clamp_rise;
  logic               clamp_q;
  logic               cal_q;
  logic [START_W-1:0] start_pos;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      start_hi_q <= '0;
      start_lo_q <= '0;
      width_q    <= REG_W'(WIDTH_RST);
      src_q      <= SRC_INTERNAL;
      lead_q     <= 1'b0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        A_START_HI: start_hi_q <= cfg_wdata[HI_W-1:0];
        A_START_LO: start_lo_q <= cfg_wdata;
        A_WIDTH:    width_q    <= cfg_wdata;
        A_CTRL: begin
          src_q  <= clamp_src_e'(cfg_wdata[1:0]);
          lead_q <= cfg_wdata[CTRL_EDGE_BIT];
        end
        default: ;
      endcase
    end
  end

  assign start_pos = {start_hi_q, start_lo_q};
  assign ext_sel   = (src_q == SRC_EXTERNAL);

  clamp_hs_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .hsync_in (hsync_in),
    .lead_sel (lead_q),
    .edge_hit (hs_edge)
  );

  clamp_window_counter #(
    .START_W (START_W),
    .WIDTH_W (REG_W)
  ) u_win (
    .clk       (clk),
    .rst       (rst),
    .restart   (hs_edge),
    .start_pos (start_pos),
    .width_px  (width_q),
    .in_window (int_pulse)
  );

  always_comb begin
    next_clamp = ext_sel ? clamp_ext_in : int_pulse;
    clamp_rise = next_clamp & ~clamp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clamp_q <= 1'b0;
      cal_q   <= 1'b0;
    end else begin
      clamp_q <= next_clamp;
      cal_q   <= clamp_rise;
    end
  end

  assign clamp_out = clamp_q;
  assign cal_start = cal_q;

  clamp_stage_bank #(
    .NCH   (NCH),
    .DW    (OFS_W),
    .REG_W (REG_W),
    .AW    (CFG_AW),
    .BASE  (A_OFS_BASE)
  ) u_ofs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_wr),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_wdata),
    .xfer     (clamp_rise),
    .act_flat (offset_act)
  );

  clamp_stage_bank #(
    .NCH   (NCH),
    .DW    (GAIN_W),
    .REG_W (REG_W),
    .AW    (CFG_AW),
    .BASE  (A_GAIN_BASE)
  ) u_gain (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_wr),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_wdata),
    .xfer     (clamp_rise),
    .act_flat (gain_act)
  );
endmodule

// File: rtl/clamp_pulse_gen_chk.sv
module clamp_pulse_gen_chk #(
  parameter int NCH    = 3,
  parameter int OFS_W  = 8,
  parameter int GAIN_W = 8,
  parameter int REG_W  = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  clamp_out,
  input logic                  cal_start,
  input logic                  clamp_ext_in,
  input logic                  ext_sel,
  input logic                  hs_edge,
  input logic [REG_W-1:0]      width_q,
  input logic [NCH*OFS_W-1:0]  offset_act,
  input logic [NCH*GAIN_W-1:0] gain_act
);
  assert_cal_on_rise_R8: assert property (@(posedge clk) disable iff (rst)
    cal_start |-> (clamp_out && !$past(clamp_out)));

  assert_rise_gives_cal_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(clamp_out) |-> cal_start);

  assert_act_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !cal_start |-> ($stable(offset_act) && $stable(gain_act)));

  assert_no_narrow_R4: assert property (@(posedge clk) disable iff (rst)
    (!ext_sel && (width_q < REG_W'(2))) |=> !$rose(clamp_out));

  assert_ext_follow_R6: assert property (@(posedge clk) disable iff (rst)
    ext_sel |=> (clamp_out == $past(clamp_ext_in)));

  assert_edge_cut_R7: assert property (@(posedge clk) disable iff (rst)
    (hs_edge && !ext_sel) |=> !clamp_out);
endmodule

bind clamp_pulse_gen clamp_pulse_gen_chk #(
  .NCH    (NCH),
  .OFS_W  (OFS_W),
  .GAIN_W (GAIN_W),
  .REG_W  (REG_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .clamp_out    (clamp_out),
  .cal_start    (cal_start),
  .clamp_ext_in (clamp_ext_in),
  .ext_sel      (ext_sel),
  .hs_edge      (hs_edge),
  .width_q      (width_q),
  .offset_act   (offset_act),
  .gain_act     (gain_act)
);

// File: tb/test_clamp_pulse_gen.sv
`timescale 1ns/1ps
module test_clamp_pulse_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hsync_in = 1'b0;
  logic        clamp_ext_in = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        clamp_out;
  logic        cal_start;
  logic [23:0] offset_act;
  logic [23:0] gain_act;

  int unsigned cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    int unsigned at;
    string       req;
    logic        clamp;
    logic        cal;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clamp_pulse_gen i_clamp_pulse_gen (
    .clk          (clk),
    .rst          (rst),
    .hsync_in     (hsync_in),
    .clamp_ext_in (clamp_ext_in),
    .cfg_wr       (cfg_wr),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .clamp_out    (clamp_out),
    .cal_start    (cal_start),
    .offset_act   (offset_act),
    .gain_act     (gain_act)
  );

  // monitor: pop expected items and compare
  always @(negedge clk) begin
    exp_t e;
    if (!rst) begin
      while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
        e = exp_q.pop_front();
        if (e.at == cyc) begin
          n_cmp++;
          if (clamp_out !== e.clamp || cal_start !== e.cal) begin
            n_bad++;
            $display("FAIL %s cycle %0d clamp/cal actual %b/%b expected %b/%b",
                     e.req, cyc, clamp_out, cal_start, e.clamp, e.cal);
          end
        end
      end
    end
  end

  task automatic push(input int unsigned at, input string req, input logic c, input logic k);
    exp_t e;
    e.at = at; e.req = req; e.clamp = c; e.cal = k;
    exp_q.push_back(e);
  endtask

  // expected internal pulse for an edge seen just before posedge c0+1
  task automatic expect_line(input int unsigned c0, input int unsigned s, input int unsigned w,
                             input int unsigned last, input string req);
    for (int unsigned t = c0 + 1; t <= last; t++) begin
      logic hi;
      hi = (w >= 2) && (t >= c0 + s + 2) && (t <= c0 + s + w + 1);
      push(t, req, hi, (w >= 2) && (t == c0 + s + 2));
    end
  endtask

  task automatic wait_cyc(input int unsigned t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic hs_trail(output int unsigned c0);
    hsync_in = 1'b1;
    repeat (3) @(negedge clk);
    hsync_in = 1'b0;
    c0 = cyc;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s cycle %0d actual %0h expected %0h", req, cyc, act, expv);
    end
  endtask

  function automatic logic [7:0] ofs(input int i);
    return offset_act[i*8 +: 8];
  endfunction
  function automatic logic [7:0] gn(input int i);
    return gain_act[i*8 +: 8];
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int unsigned c0;
    int unsigned c1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 clamp", 32'(clamp_out), 0);
    chk("R1 cal", 32'(cal_start), 0);
    chk("R1 offsets", 32'(offset_act), 0);
    chk("R1 gains", 32'(gain_act), 0);

    // R1/R2 default width 16, start 0
    hs_trail(c0);
    expect_line(c0, 0, 16, c0 + 22, "R1 default width/R2");
    wait_cyc(c0 + 22);

    // R3 split start position 0x105, R2 width 3
    wr(4'h0, 8'h01);
    wr(4'h1, 8'h05);
    wr(4'h2, 8'd3);
    hs_trail(c0);
    expect_line(c0, 261, 3, c0 + 270, "R3 start 0x105");
    wait_cyc(c0 + 270);

    // R4 narrow widths
    wr(4'h0, 8'h00);
    wr(4'h1, 8'd5);
    wr(4'h2, 8'd0);
    hs_trail(c0);
    expect_line(c0, 5, 0, c0 + 12, "R4 width 0");
    wait_cyc(c0 + 12);
    wr(4'h2, 8'd1);
    hs_trail(c0);
    expect_line(c0, 5, 1, c0 + 12, "R4 width 1");
    wait_cyc(c0 + 12);
    wr(4'h2, 8'd2);
    hs_trail(c0);
    expect_line(c0, 5, 2, c0 + 12, "R4 width 2");
    wait_cyc(c0 + 12);

    // R5 leading edge select; trailing edge then ignored
    wr(4'h3, 8'h04);
    hsync_in = 1'b1;
    c0 = cyc;
    expect_line(c0, 5, 2, c0 + 15, "R5 rising edge");
    wait_cyc(c0 + 15);
    hsync_in = 1'b0;
    c1 = cyc;
    expect_line(c1, 5, 0, c1 + 15, "R5 falling ignored");
    wait_cyc(c1 + 15);
    wr(4'h3, 8'h00);

    // R6 external source, R9 transfer on external edge
    wr(4'h6, 8'h5A);
    wr(4'h3, 8'h01);
    hs_trail(c0);
    expect_line(c0, 5, 0, c0 + 12, "R6 internal suppressed");
    wait_cyc(c0 + 12);
    wr(4'h2, 8'd0);
    chk("R9 ch2 held before ext edge", 32'(ofs(2)), 0);
    clamp_ext_in = 1'b1;
    c0 = cyc;
    push(c0 + 1, "R6/R8 ext rise", 1'b1, 1'b1);
    for (int unsigned t = c0 + 2; t <= c0 + 4; t++) push(t, "R6 ext high width ignored", 1'b1, 1'b0);
    for (int unsigned t = c0 + 5; t <= c0 + 7; t++) push(t, "R6 ext low", 1'b0, 1'b0);
    wait_cyc(c0 + 1);
    chk("R9 ch2 on ext edge", 32'(ofs(2)), 32'h5A);
    wait_cyc(c0 + 4);
    clamp_ext_in = 1'b0;
    wait_cyc(c0 + 7);

    // R6 code 10 selects internal
    wr(4'h3, 8'h02);
    wr(4'h2, 8'd3);
    hs_trail(c0);
    expect_line(c0, 5, 3, c0 + 14, "R6 code 10 internal");
    wait_cyc(c0 + 14);
    wr(4'h3, 8'h00);

    // R7 new edge mid-pulse, R8 two strobes
    wr(4'h1, 8'd2);
    wr(4'h2, 8'd20);
    hs_trail(c0);
    expect_line(c0, 2, 20, c0 + 8, "R7 first pulse");
    expect_line(c0 + 8, 2, 20, c0 + 34, "R7 restarted pulse");
    wait_cyc(c0 + 6);
    hsync_in = 1'b1;
    wait_cyc(c0 + 8);
    hsync_in = 1'b0;
    wait_cyc(c0 + 34);

    // R9/R10 staging, repeated writes
    wr(4'h1, 8'd4);
    wr(4'h2, 8'd3);
    wr(4'h4, 8'h33);
    wr(4'h4, 8'h44);
    wr(4'h9, 8'h22);
    chk("R9 ofs0 held after write", 32'(ofs(0)), 0);
    chk("R9 gain1 held after write", 32'(gn(1)), 0);
    hs_trail(c0);
    expect_line(c0, 4, 3, c0 + 12, "R9 pulse");
    wait_cyc(c0 + 5);
    chk("R9 ofs0 before edge", 32'(ofs(0)), 0);
    wait_cyc(c0 + 6);
    chk("R10 ofs0 last write", 32'(ofs(0)), 32'h44);
    chk("R9 gain1 transferred", 32'(gn(1)), 32'h22);
    wait_cyc(c0 + 12);

    // R10 write on the same edge as the transfer
    hs_trail(c0);
    expect_line(c0, 4, 3, c0 + 12, "R10 pulse");
    wait_cyc(c0 + 5);
    wr(4'h4, 8'h77);
    chk("R10 same-cycle write", 32'(ofs(0)), 32'h77);
    wait_cyc(c0 + 12);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule